// File: doc/BRIEF.md
# Multi-Lane LFSR Random Word Generator

This block produces a pseudorandom word of `LANES` bits every cycle it is stepped. Inside are `LANES` separate Fibonacci linear feedback shift registers, each `WIDTH` bits long. One bit is taken from each register, at a fixed position `PICK`, and these bits are placed side by side. Output bit i always comes from register i. Neighbouring output bits therefore come from registers with separate seeds, not from adjacent stages of one register.

Software-free control is kept minimal. A load strobe copies a seed from a wide seed bus into every lane in the same cycle. An enable input advances all lanes together. A seed that is all zeros is replaced by the value 1, so no lane can stick at zero. The feedback polynomial is fixed when the block is elaborated. The default is a primitive degree-8 polynomial, so each lane runs through all 255 nonzero states before it repeats.

Top module: `multi_lfsr_word`

## Requirements
- R1: Synchronous active-high reset sets every lane's state to 1 (only the lowest bit set) and drives `valid` low; with the default configuration the word reads 0 after reset and all ones after seven enabled steps.
- R2: A cycle with `load` high writes every lane's seed at once; lane i takes `seed_bus[i*WIDTH +: WIDTH]`, and the word after that edge shows the new seeds' bits at position `PICK`.
- R3: A lane whose seed field is all zeros is loaded with 1 instead, and a lane's state is never zero.
- R4: On an enabled step each lane shifts left by one, and the new lowest bit is the XOR of the state bits selected by `TAPS`; the default taps are bit positions 8, 6, 5 and 4, counting from 1 at the LSB (mask 8'hB8).
- R5: With the default taps, every lane returns to its loaded state after exactly 255 enabled steps.
- R6: With `load` and `en` both low, every lane keeps its state and the word is unchanged.
- R7: When `load` and `en` are high in the same cycle, the seeds are loaded and no shift takes place.
- R8: `valid` goes high after the first cycle with `en` high and `load` low that follows a load; it stays high through later loads and steps, and only reset clears it; enables that come before any load leave it low.
- R9: A 3-bit lane with taps at positions 3 and 2 (mask 3'b110) and seed 001 steps through 001, 010, 101, 011, 111, 110, 100 and then returns to 001.
- R10: Output bit i is bit `PICK` of lane i, and each lane runs on its own seed without affecting any other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Copy all seeds into the lanes |
| en | input | 1 | Advance all lanes by one step |
| seed_bus | input | LANES*WIDTH | Seeds, lane i in bits [i*WIDTH +: WIDTH] |
| word | output | LANES | One bit from each lane, bit i from lane i |
| valid | output | 1 | High once stepping has started after a load |

## Verification
Every result is due one clock edge after the control that causes it. The lane registers drive `word` through wiring alone, so a load or a step is visible right after the edge that samples it. `valid` is likewise set by the edge that samples the first qualifying enable. The bench changes inputs and samples outputs two nanoseconds after each rising edge. This means every check reads the state produced by the edge just passed, and the controls applied for the next edge.

// File: rtl/prng_pkg.sv
package prng_pkg;

    // What each lane does on the next clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SEED  = 2'd1,
        OP_SHIFT = 2'd2
    } lane_op_e;

    typedef struct packed {
        logic load;
        logic en;
    } lane_ctl_t;

    localparam int DEF_LANES = 8;
    localparam int DEF_WIDTH = 8;
    localparam logic [7:0] DEF_TAPS = 8'hB8;

    // Load wins over stepping.
    function automatic lane_op_e decode_op(lane_ctl_t c);
        if (c.load)
            return OP_SEED;
        else if (c.en)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/seed_guard.sv
module seed_guard #(
    parameter int W = 8
) (
    input  logic [W-1:0] seed_in,
    output logic [W-1:0] seed_safe
);
    localparam logic [W-1:0] FILL = W'(1);

    always_comb begin
        seed_safe = (seed_in == '0) ? FILL : seed_in;
    end
endmodule

// File: rtl/lfsr_lane.sv
module lfsr_lane
    import prng_pkg::*;
#(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = W'(8'hB8)
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_op_e     op,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] START = W'(1);

    logic feedback;

    always_comb begin
        feedback = ^(state & TAPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= START;
        end else begin
            unique case (op)
                OP_SEED:  state <= seed;
                OP_SHIFT: state <= {state[W-2:0], feedback};
                default:  state <= state;
            endcase
        end
    end

    assert_never_zero_R3: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    assert_seed_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEED) |=> (state == $past(seed)));

    assert_shift_left_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (state[W-1:1] == $past(state[W-2:0])));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(state));
endmodule

// File: rtl/valid_tracker.sv
module valid_tracker
    import prng_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lane_op_e op,
    output logic     valid
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            valid <= 1'b0;
        end else begin
            if (op == OP_SEED)
                armed <= 1'b1;
            if (armed && op == OP_SHIFT)
                valid <= 1'b1;
        end
    end

    assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    assert_valid_after_step_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(op == OP_SHIFT));
endmodule

// File: rtl/multi_lfsr_word.sv
module multi_lfsr_word
    import prng_pkg::*;
#(
    parameter int               LANES = DEF_LANES,
    parameter int               WIDTH = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAPS  = WIDTH'(DEF_TAPS),
    parameter int               PICK  = WIDTH - 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   en,
    input  logic [LANES*WIDTH-1:0] seed_bus,
    output logic [LANES-1:0]       word,
    output logic                   valid
);
    localparam int SEED_W = LANES * WIDTH;

    lane_ctl_t ctl;
    lane_op_e  op;

    always_comb begin
        ctl.load = load;
        ctl.en   = en;
        op       = decode_op(ctl);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WIDTH-1:0] raw_seed;
        logic [WIDTH-1:0] safe_seed;
        logic [WIDTH-1:0] lane_state;

        assign raw_seed = seed_bus[i*WIDTH +: WIDTH];

        seed_guard #(.W(WIDTH)) u_guard (
            .seed_in   (raw_seed),
            .seed_safe (safe_seed)
        );

        lfsr_lane #(.W(WIDTH), .TAPS(TAPS)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .seed  (safe_seed),
            .state (lane_state)
        );

        assign word[i] = lane_state[PICK];
    end

    valid_tracker u_valid (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .valid (valid)
    );

    initial begin
        assert_pick_in_range_R10: assert (PICK >= 0 && PICK < WIDTH && SEED_W == LANES * WIDTH);
    end
endmodule

// File: tb/multi_lfsr_word_tb.sv
module multi_lfsr_word_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_a = 1'b0, en_a = 1'b0;
    logic load_b = 1'b0, en_b = 1'b0;
    logic [63:0] seed_a = '0;
    logic [8:0]  seed_b = '0;
    logic [7:0]  word_a;
    logic [2:0]  word_b;
    logic        valid_a, valid_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    multi_lfsr_word u_dut (
        .clk(clk), .rst(rst), .load(load_a), .en(en_a),
        .seed_bus(seed_a), .word(word_a), .valid(valid_a)
    );

    multi_lfsr_word #(.LANES(3), .WIDTH(3), .TAPS(3'b110), .PICK(0)) u_dut_small (
        .clk(clk), .rst(rst), .load(load_b), .en(en_b),
        .seed_bus(seed_b), .word(word_b), .valid(valid_b)
    );

    logic [7:0] mdl [8];
    logic [7:0] after_load;

    function automatic logic [7:0] adv8(logic [7:0] s);
        return {s[6:0], ^(s & 8'hB8)};
    endfunction

    function automatic logic [7:0] msb_word();
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[i] = mdl[i][7];
        return w;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [7:0] seeds [8];
        logic [2:0] seq [7];
        seeds = '{8'h01, 8'h5A, 8'h00, 8'hFF, 8'h80, 8'h33, 8'hC4, 8'h0F};
        seq   = '{3'b001, 3'b010, 3'b101, 3'b011, 3'b111, 3'b110, 3'b100};

        cyc(); cyc();
        rst = 1'b0;
        // R1: reset state
        chk("R1 word after reset", word_a, 8'h00);
        chk("R1 valid after reset", valid_a, 1'b0);

        en_a = 1'b1;
        for (int k = 0; k < 7; k++) cyc();
        en_a = 1'b0;
        chk("R1 seven steps from reset", word_a, 8'hFF);
        chk("R8 no valid without load", valid_a, 1'b0);

        // R2/R3: load all lanes, lane 2 has zero seed
        for (int i = 0; i < 8; i++) seed_a[i*8 +: 8] = seeds[i];
        load_a = 1'b1;
        cyc();
        load_a = 1'b0;
        for (int i = 0; i < 8; i++) mdl[i] = (seeds[i] == 8'h00) ? 8'h01 : seeds[i];
        after_load = msb_word();
        chk("R2 word after load", word_a, after_load);
        chk("R8 load alone keeps valid low", valid_a, 1'b0);

        // R6: hold
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R6 hold with en low", word_a, after_load);
        end

        // R4/R10/R3: full period against model
        en_a = 1'b1;
        for (int k = 1; k <= 255; k++) begin
            cyc();
            for (int i = 0; i < 8; i++) mdl[i] = adv8(mdl[i]);
            chk("R4 R10 word per step", word_a, msb_word());
            chk("R3 zero-seed lane runs", word_a[2], mdl[2][7]);
            if (k == 1) chk("R8 valid after first step", valid_a, 1'b1);
            if (k == 7) chk("R3 zero-seed lane left zero", word_a[2], 1'b1);
        end
        en_a = 1'b0;
        chk("R5 period of 255 returns to seeds", word_a, after_load);
        chk("R5 model lane 1 back to seed", mdl[1], seeds[1]);

        // R7: load and enable together
        for (int i = 0; i < 8; i++) begin
            seeds[i] = 8'h80 >> i;
            seed_a[i*8 +: 8] = seeds[i];
        end
        load_a = 1'b1; en_a = 1'b1;
        cyc();
        load_a = 1'b0; en_a = 1'b0;
        chk("R7 load wins over enable", word_a, 8'h01);
        chk("R8 valid kept across load", valid_a, 1'b1);

        // R8: only reset clears valid
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        chk("R8 reset clears valid", valid_a, 1'b0);

        // R9: 3-bit sequence on the small instance, LSB picked
        seed_b = {3'b000, 3'b010, 3'b001};
        load_b = 1'b1;
        cyc();
        load_b = 1'b0;
        en_b = 1'b1;
        for (int k = 0; k <= 7; k++) begin
            chk("R9 three-bit sequence",
                word_b, {seq[k % 7][0], seq[(k + 1) % 7][0], seq[k % 7][0]});
            cyc();
        end
        en_b = 1'b0;
        chk("R8 small instance valid", valid_b, 1'b1);

        report();
    end
endmodule